// File: doc/BRIEF.md
# Flow-Through Zero-Turnaround Synchronous SRAM

This block is a small synchronous static memory whose shared data path never stands idle between a write and a following read. It registers every command on the rising clock edge. A read presents array data combinationally in the cycle right after its command edge, with no output register. A write takes its data one cycle after its address. That data is committed on the same edge that registers the next command, so any mix of reads and writes can run every cycle. The bidirectional data bus appears as a separate data input, data output and output-drive enable.

The word is split into byte lanes, and each lane carries its own parity bit, giving 4 lanes of 9 bits by default. A write updates only the lanes whose select is active. Three chip-select inputs must all agree for a command to be accepted. An advance input continues a four-beat burst from the last loaded address, in either linear or interleaved order. A clock-enable input freezes the block for a cycle. A sleep input blocks new commands and turns the outputs off. The output-enable pin acts on the drive enable without waiting for a clock edge.

There is no valid/ready handshake. The block accepts a transfer on every enabled edge. Clock enable is its only form of back-pressure, and it stalls the command and data phases together.

Top module: `zt_sram`

## Requirements
- R1: A read command is registered on a rising edge of `clk` with `clk_en` high. In the cycle that follows, `dout` shows the stored word and `dout_oe` is high when `oe_n` is low and `sleep` is low. No further edge is needed.
- R2: Write data on `din` is captured at the enabled edge after the write command's edge. A read registered at that same edge returns the new data at once, with no idle cycle between them.
- R3: A command is accepted only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0 and `adv` is low. Any other combination is a deselect: nothing is written and `dout_oe` is low in the following cycle.
- R4: Lane i of the word is bits [9i+8:9i]. `byte_wr_n[i]`=0 during the write command writes that lane. Lanes with a high select keep their old contents.
- R5: A write command with all `byte_wr_n` bits high leaves the addressed word unchanged.
- R6: In the cycle after a write command (its data phase), `dout_oe` is low whatever the level of `oe_n`.
- R7: `oe_n` high forces `dout_oe` low combinationally, without a clock edge. Returning it low restores drive in the same cycle.
- R8: An edge with `clk_en` low writes nothing and changes no state. `dout` and `dout_oe` hold their values, and a pending write waits for the next enabled edge to take its data.
- R9: While `sleep` is high, `dout_oe` is low at once. Commands presented at edges during sleep have no effect.
- R10: `adv` high with `burst_ilv`=0 repeats the last loaded operation. The low two address bits step linearly, start+1, start+2, start+3 modulo 4, and the upper bits are kept.
- R11: `adv` high with `burst_ilv`=1 steps the low two address bits as start XOR 1, start XOR 2, start XOR 3.
- R12: After reset, `dout_oe` is low until a read command is registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| clk_en | input | 1 | High enables the edge; low stalls the block |
| sleep | input | 1 | Power-down: blocks commands and disables drive |
| addr | input | ADDR_W | Word address of a loaded command |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Low selects write, high selects read |
| byte_wr_n | input | LANES | Per-lane write selects, active low |
| adv | input | 1 | High continues the current burst |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| din | input | LANES*LANE_W | Write data, one cycle after the write command |
| dout | output | LANES*LANE_W | Read data, flow-through |
| dout_oe | output | 1 | High when the block drives the data bus |

## Verification
The hardest state to reach is a write whose data phase is stretched by a low clock enable while the next command already sits on the pins. Only the data present at the next enabled edge may land, and the read registered at that edge must return it. The bench issues a write and then a stalled cycle with different data and a read on the pins. It releases the stall with new data and checks that only the new data comes back. Burst wrap in both orders is reached by loading start addresses whose low bits are not zero and then reading back every beat address on its own.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } zt_op_e;
endpackage

// File: rtl/zt_burst_seq.sv
// Next beat of a burst: linear adds, interleaved XORs the beat count into the start.
module zt_burst_seq #(
  parameter int BURST_W = 2
) (
  input  logic [BURST_W-1:0] start_lo,
  input  logic [BURST_W-1:0] cnt,
  input  logic               ilv,
  output logic [BURST_W-1:0] next_lo,
  output logic [BURST_W-1:0] next_cnt
);
  always_comb begin
    next_cnt = cnt + 1'b1;
    next_lo  = ilv ? (start_lo ^ next_cnt) : (start_lo + next_cnt);
  end
endmodule

// File: rtl/zt_cmd_ctl.sv
// Command register. Its contents also serve as the one-entry pending-write
// record that commits on the next enabled edge.
module zt_cmd_ctl
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 4,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              sleep,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              cs3_n,
  input  logic              wr_n,
  input  logic [LANES-1:0]  byte_wr_n,
  input  logic              adv,
  input  logic              burst_ilv,
  output zt_op_e            op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [LANES-1:0]  mask_q
);
  zt_op_e             burst_op_q, nxt_op, nxt_burst_op;
  logic [BURST_W-1:0] start_q, cnt_q, nxt_start, nxt_cnt;
  logic [BURST_W-1:0] step_lo, step_cnt;
  logic [ADDR_W-1:0]  nxt_addr;
  logic               sel;

  zt_burst_seq #(.BURST_W(BURST_W)) u_seq (
    .start_lo (start_q),
    .cnt      (cnt_q),
    .ilv      (burst_ilv),
    .next_lo  (step_lo),
    .next_cnt (step_cnt)
  );

  always_comb begin
    sel          = !cs1_n && cs2 && !cs3_n;
    nxt_op       = OP_IDLE;
    nxt_burst_op = burst_op_q;
    nxt_addr     = addr_q;
    nxt_start    = start_q;
    nxt_cnt      = cnt_q;
    if (sleep) begin
      nxt_burst_op = OP_IDLE;
    end else if (adv) begin
      nxt_op   = burst_op_q;
      nxt_addr = {addr_q[ADDR_W-1:BURST_W], step_lo};
      nxt_cnt  = step_cnt;
    end else begin
      if (sel) nxt_op = wr_n ? OP_READ : OP_WRITE;
      nxt_burst_op = nxt_op;
      nxt_addr     = addr;
      nxt_start    = addr[BURST_W-1:0];
      nxt_cnt      = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q       <= OP_IDLE;
      burst_op_q <= OP_IDLE;
      addr_q     <= '0;
      mask_q     <= '0;
      start_q    <= '0;
      cnt_q      <= '0;
    end else if (clk_en) begin
      op_q       <= nxt_op;
      burst_op_q <= nxt_burst_op;
      addr_q     <= nxt_addr;
      mask_q     <= ~byte_wr_n;
      start_q    <= nxt_start;
      cnt_q      <= nxt_cnt;
    end
  end
endmodule

// File: rtl/zt_lane_mem.sv
// Storage split into byte lanes: synchronous per-lane write, combinational read.
module zt_lane_mem #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [LANES-1:0]        mask,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    always_ff @(posedge clk) begin
      if (we && mask[g]) cells[addr] <= wdata[g*LANE_W +: LANE_W];
    end
    assign rdata[g*LANE_W +: LANE_W] = cells[addr];
  end
endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 4,
  parameter int LANE_W  = 9,
  parameter int BURST_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clk_en,
  input  logic                    sleep,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    cs1_n,
  input  logic                    cs2,
  input  logic                    cs3_n,
  input  logic                    wr_n,
  input  logic [LANES-1:0]        byte_wr_n,
  input  logic                    adv,
  input  logic                    burst_ilv,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_oe
);
  localparam int DATA_W = LANES * LANE_W;

  zt_op_e            op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  mask_q;
  logic [DATA_W-1:0] rdata;
  logic              commit;

  zt_cmd_ctl #(.ADDR_W(ADDR_W), .LANES(LANES), .BURST_W(BURST_W)) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en    (clk_en),
    .sleep     (sleep),
    .addr      (addr),
    .cs1_n     (cs1_n),
    .cs2       (cs2),
    .cs3_n     (cs3_n),
    .wr_n      (wr_n),
    .byte_wr_n (byte_wr_n),
    .adv       (adv),
    .burst_ilv (burst_ilv),
    .op_q      (op_q),
    .addr_q    (addr_q),
    .mask_q    (mask_q)
  );

  // The data phase of a registered write completes on the next enabled edge.
  assign commit = clk_en && (op_q == OP_WRITE);

  zt_lane_mem #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk   (clk),
    .we    (commit),
    .mask  (mask_q),
    .addr  (addr_q),
    .wdata (din),
    .rdata (rdata)
  );

  assign dout    = (op_q == OP_READ) ? rdata : '0;
  assign dout_oe = !oe_n && !sleep && (op_q == OP_READ);
endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en,
  input logic              sleep,
  input logic              cs1_n,
  input logic              cs2,
  input logic              cs3_n,
  input logic              wr_n,
  input logic              adv,
  input logic              oe_n,
  input logic [DATA_W-1:0] dout,
  input logic              dout_oe
);
  logic sel;
  assign sel = !cs1_n && cs2 && !cs3_n;

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> (!$stable(oe_n) || !$stable(sleep) || ($stable(dout_oe) && $stable(dout))));

  // R6
  write_phase_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !sleep && !adv && sel && !wr_n) |=> !dout_oe);

  // R3
  deselect_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !sleep && !adv && !sel) |=> !dout_oe);

  // R9
  sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dout_oe);

  // R7
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_oe);

  // R1
  read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !sleep && !adv && sel && wr_n) |=> (oe_n || sleep || dout_oe));
endmodule

bind zt_sram zt_sram_chk u_chk (.*);

// File: tb/test_zt_sram.sv
module test_zt_sram;
  logic        clk = 1'b0;
  logic        rst_n, clk_en, sleep, cs1_n, cs2, cs3_n, wr_n, adv, burst_ilv, oe_n;
  logic [5:0]  addr;
  logic [3:0]  byte_wr_n;
  logic [35:0] din, dout;
  logic        dout_oe;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  zt_sram i_zt_sram (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sleep(sleep), .addr(addr),
    .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .wr_n(wr_n), .byte_wr_n(byte_wr_n),
    .adv(adv), .burst_ilv(burst_ilv), .oe_n(oe_n), .din(din),
    .dout(dout), .dout_oe(dout_oe)
  );

  // op: 0 read, 1 write. cs_bad bits: [2] cs1_n high, [1] cs2 low, [0] cs3_n high.
  typedef struct packed {
    logic        op;
    logic [2:0]  cs_bad;
    logic [3:0]  be_n;
    logic [5:0]  a;
    logic [35:0] d;
    logic        eoe;
    logic [35:0] ed;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 3'b000, 4'h0, 6'd5, 36'h0,         1'b0, 36'h0},          // R6 write A5
    '{1'b1, 3'b000, 4'h0, 6'd6, 36'h123456789, 1'b0, 36'h0},          // R2 data A5, write A6
    '{1'b0, 3'b000, 4'hF, 6'd5, 36'h987654321, 1'b1, 36'h123456789},  // R2 R1 read right after write
    '{1'b0, 3'b000, 4'hF, 6'd6, 36'h0,         1'b1, 36'h987654321},  // R1
    '{1'b1, 3'b000, 4'hE, 6'd5, 36'h0,         1'b0, 36'h0},          // R4 lane 0 only
    '{1'b0, 3'b000, 4'hF, 6'd5, 36'hFFFFFFFAB, 1'b1, 36'h1234567AB},  // R4
    '{1'b1, 3'b000, 4'hF, 6'd6, 36'h0,         1'b0, 36'h0},          // R5 no lanes
    '{1'b0, 3'b000, 4'hF, 6'd6, 36'hFFFFFFFFF, 1'b1, 36'h987654321},  // R5
    '{1'b1, 3'b010, 4'h0, 6'd5, 36'h0,         1'b0, 36'h0},          // R3 cs2 low
    '{1'b0, 3'b000, 4'hF, 6'd5, 36'h0,         1'b1, 36'h1234567AB},  // R3 nothing written
    '{1'b0, 3'b100, 4'hF, 6'd6, 36'h0,         1'b0, 36'h0},          // R3 cs1_n high
    '{1'b0, 3'b001, 4'hF, 6'd6, 36'h0,         1'b0, 36'h0}           // R3 cs3_n high
  };

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic chk(input string tag, input logic eoe, input logic [35:0] ed);
    checks++;
    if (dout_oe !== eoe || (eoe && dout !== ed)) begin
      errors++;
      $display("FAIL %s: dout_oe=%0b dout=%h expected dout_oe=%0b dout=%h",
               tag, dout_oe, dout, eoe, ed);
    end
  endtask

  // op: 0 read, 1 write, 2 deselect
  task automatic set_cmd(input int op, input logic [5:0] a, input logic [3:0] be);
    cs1_n = 1'b0; cs2 = (op != 2); cs3_n = 1'b0;
    wr_n = (op != 1); addr = a; byte_wr_n = be; adv = 1'b0;
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; clk_en = 1; sleep = 0; burst_ilv = 0; oe_n = 0; din = '0;
    set_cmd(2, 6'd0, 4'hF);
    repeat (3) tick();
    chk("R12 in reset", 1'b0, 36'h0);
    rst_n = 1;
    tick();
    chk("R12 after reset", 1'b0, 36'h0);

    for (int i = 0; i < NV; i++) begin
      cs1_n = VECS[i].cs_bad[2]; cs2 = !VECS[i].cs_bad[1]; cs3_n = VECS[i].cs_bad[0];
      wr_n = !VECS[i].op; byte_wr_n = VECS[i].be_n; addr = VECS[i].a;
      adv = 1'b0; din = VECS[i].d;
      tick();
      chk($sformatf("table row %0d (R1 R2 R3 R4 R5 R6)", i), VECS[i].eoe, VECS[i].ed);
    end

    // R10 linear burst from low bits 2: 0x0A, 0x0B, 0x08, 0x09
    set_cmd(1, 6'h0A, 4'h0); tick();
    adv = 1; din = 36'hA00; tick();
    din = 36'hA01; tick();
    din = 36'hA02; tick();
    set_cmd(2, 6'h0, 4'hF); din = 36'hA03; tick();
    set_cmd(0, 6'h08, 4'hF); tick(); chk("R10 beat 3", 1'b1, 36'hA02);
    set_cmd(0, 6'h09, 4'hF); tick(); chk("R10 beat 4", 1'b1, 36'hA03);
    set_cmd(0, 6'h0A, 4'hF); tick(); chk("R10 beat 1", 1'b1, 36'hA00);
    set_cmd(0, 6'h0B, 4'hF); tick(); chk("R10 read load", 1'b1, 36'hA01);
    adv = 1; tick(); chk("R10 read wrap", 1'b1, 36'hA02);

    // R11 interleaved burst from low bits 1: 0x11, 0x10, 0x13, 0x12
    burst_ilv = 1;
    set_cmd(1, 6'h11, 4'h0); tick();
    adv = 1; din = 36'hB00; tick();
    din = 36'hB01; tick();
    din = 36'hB02; tick();
    set_cmd(2, 6'h0, 4'hF); din = 36'hB03; tick();
    burst_ilv = 0;
    set_cmd(0, 6'h12, 4'hF); tick(); chk("R11 beat 4", 1'b1, 36'hB03);
    set_cmd(0, 6'h10, 4'hF); tick(); chk("R11 beat 2", 1'b1, 36'hB01);
    set_cmd(0, 6'h13, 4'hF); tick(); chk("R11 beat 3", 1'b1, 36'hB02);

    // R8 stall holds a read; R7 asynchronous output enable
    set_cmd(0, 6'd5, 4'hF); tick(); chk("R8 before stall", 1'b1, 36'h1234567AB);
    clk_en = 0; set_cmd(0, 6'd6, 4'hF); tick();
    chk("R8 stalled read", 1'b1, 36'h1234567AB);
    oe_n = 1; #2; chk("R7 oe_n high", 1'b0, 36'h0);
    oe_n = 0; #2; chk("R7 oe_n low", 1'b1, 36'h1234567AB);
    clk_en = 1;

    // R8 stall inside a write data phase
    set_cmd(1, 6'd6, 4'h0); tick(); chk("R6 write phase", 1'b0, 36'h0);
    clk_en = 0; din = 36'h0DEADBEEF; set_cmd(0, 6'd6, 4'hF); tick();
    chk("R8 stalled write phase", 1'b0, 36'h0);
    clk_en = 1; din = 36'h5A5A5A5A5; tick();
    chk("R8 data after stall", 1'b1, 36'h5A5A5A5A5);

    // R9 sleep
    set_cmd(0, 6'd5, 4'hF); tick(); chk("R9 before sleep", 1'b1, 36'h1234567AB);
    sleep = 1; #2; chk("R9 sleep drops drive", 1'b0, 36'h0);
    set_cmd(1, 6'd5, 4'h0); din = 36'h0; tick(); chk("R9 write ignored", 1'b0, 36'h0);
    set_cmd(0, 6'd5, 4'hF); tick(); chk("R9 read ignored", 1'b0, 36'h0);
    sleep = 0; tick(); chk("R9 word intact", 1'b1, 36'h1234567AB);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule